// File: doc/BRIEF.md
# Manchester Frame Receiver for a Lighting-Control Bus

This block receives Manchester-coded forward frames from a single-wire lighting-control bus that carries no clock. A clock divider produces a sample strobe at `HALF_SMP` strobes per half-bit. The receiver times everything from these strobes. It first measures a quiet period, and only then treats a falling line as the start of a frame. There is no preamble. The start bit is confirmed by a level check at three quarters of the bit. Eight data bits follow, most significant bit first. A closing quiet period ends the frame.

When a byte is accepted, it appears on `rx_byte_o` together with a one-clock `rx_valid_o` strobe. A frame that breaks the coding or timing rules is dropped. The receiver then pulses `rx_err_o`, and `rx_err_timing_o` tells a coding fault from a timing fault. Three status flags are decoded from the held byte. Two of them apply when the byte is a gear status answer, and one applies when it is a failure-status answer.

Top module: `mrx_top`

## Requirements
- R1: `bus_idle_o` rises only after the sampled line has stayed high for `IDLE_BITS` bit times (64 samples by default). A low sample restarts this count. After reset, `bus_idle_o`, `rx_valid_o`, `rx_err_o`, `rx_byte_o` and the flags are all zero.
- R2: A low level that arrives before the bus is idle produces neither a byte nor an error. In particular, a frame sent less than the idle time after an error is ignored.
- R3: A start bit must read low at one quarter of the bit and high at three quarters. Otherwise the frame is dropped with a coding error (`rx_err_timing_o` = 0).
- R4: The first data bit after the start bit lands in `rx_byte_o[7]` and the last lands in `rx_byte_o[0]`.
- R5: A data bit 1 is low in the first half and high in the second half. A data bit 0 is the reverse. The bit is read at one quarter and at three quarters of its period.
- R6: If the quarter and three-quarter samples of a bit are equal, the receiver pulses `rx_err_o` with `rx_err_timing_o` = 0 and delivers no byte.
- R7: A mid-bit edge up to `HALF_SMP/4` samples from its nominal time is accepted, and the bit clock re-aligns to it. An edge outside both the mid-bit window and the bit-boundary window aborts the frame with `rx_err_o` and `rx_err_timing_o` = 1.
- R8: After the eighth data bit, the line must stay high for the idle time. The receiver then gives one clock of `rx_valid_o`, and `bus_idle_o` is already high. A low level after the boundary window, such as a ninth bit, gives a timing error instead.
- R9: `arc_on_o` equals bit 2 of `rx_byte_o`, and `fade_run_o` equals bit 4.
- R10: `lamp_fail_o` is the OR of bits 0 to 4 of `rx_byte_o`.
- R11: `rx_byte_o` changes only together with `rx_valid_o`. A dropped frame leaves the last good byte in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Bus data level, asynchronous; high when idle |
| bus_idle_o | output | 1 | Quiet time met, waiting for a start bit |
| rx_byte_o | output | 8 | Last accepted byte |
| rx_valid_o | output | 1 | One-clock strobe when a byte is accepted |
| rx_err_o | output | 1 | One-clock strobe when a frame is dropped |
| rx_err_timing_o | output | 1 | Kind of the last drop: 1 timing, 0 coding |
| arc_on_o | output | 1 | Arc power on flag from the status byte |
| fade_run_o | output | 1 | Fade running flag from the status byte |
| lamp_fail_o | output | 1 | OR of failure-status bits 0 to 4 |

## Verification
A bit counter that has drifted or failed to re-align shows up within the same bit. It appears either as a coding error at the three-quarter sample or as a timing error at the next edge. Otherwise it appears as a wrong byte value about two bit times later, when `rx_valid_o` fires. A bit index that is off by one shows at the ports in one of two ways. One is a timing error from the closing check. The other is a byte shifted by one position, which the MSB-first vectors expose. A wrong idle count shows as a missing `bus_idle_o` or as a frame that should have been ignored but was accepted, visible within one frame time.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
    // receiver sequencing
    typedef enum logic [1:0] {
        S_WAIT  = 2'd0,   // counting quiet samples
        S_ARMED = 2'd1,   // quiet met, waiting for a falling level
        S_BIT   = 2'd2,   // inside the start bit or a data bit
        S_STOP  = 2'd3    // closing quiet period after the last bit
    } rx_state_e;
endpackage

// File: rtl/mrx_sync.sv
module mrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    // reset to the idle (high) level of the bus
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mrx_tick.sv
module mrx_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(DIV);
            localparam logic [DW-1:0] TOP = DW'(DIV - 1);
            logic [DW-1:0] div_d, div_q;

            always_comb begin
                div_d = (div_q == TOP) ? '0 : div_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) div_q <= '0;
                else        div_q <= div_d;
            end

            assign tick_o = (div_q == TOP);
        end
    endgenerate
endmodule

// File: rtl/mrx_flags.sv
module mrx_flags (
    input  logic [4:0] low_bits_i,
    output logic       arc_on_o,
    output logic       fade_run_o,
    output logic       lamp_fail_o
);
    localparam int ARC_POS  = 2;
    localparam int FADE_POS = 4;

    always_comb begin
        arc_on_o    = low_bits_i[ARC_POS];
        fade_run_o  = low_bits_i[FADE_POS];
        lamp_fail_o = |low_bits_i;
    end
endmodule

// File: rtl/mrx_top.sv
module mrx_top #(
    parameter int CLK_DIV   = 4,
    parameter int HALF_SMP  = 16,
    parameter int IDLE_BITS = 2,
    parameter int DATA_BITS = 8,
    parameter int SYNC_LEN  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_i,
    output logic                 bus_idle_o,
    output logic [DATA_BITS-1:0] rx_byte_o,
    output logic                 rx_valid_o,
    output logic                 rx_err_o,
    output logic                 rx_err_timing_o,
    output logic                 arc_on_o,
    output logic                 fade_run_o,
    output logic                 lamp_fail_o
);
    import mrx_pkg::*;

    localparam int BIT_SMP  = 2 * HALF_SMP;
    localparam int IDLE_SMP = IDLE_BITS * BIT_SMP;
    localparam int TOL      = HALF_SMP / 4;
    localparam int CW       = $clog2(IDLE_SMP + 1);
    localparam int IW       = $clog2(DATA_BITS + 1);

    localparam logic [CW-1:0] C_ONE     = CW'(1);
    localparam logic [CW-1:0] C_Q1      = CW'(HALF_SMP / 2);
    localparam logic [CW-1:0] C_Q3      = CW'(HALF_SMP + HALF_SMP / 2);
    localparam logic [CW-1:0] C_TOL     = CW'(TOL);
    localparam logic [CW-1:0] C_MID_LO  = CW'(HALF_SMP - TOL);
    localparam logic [CW-1:0] C_MID_HI  = CW'(HALF_SMP + TOL);
    localparam logic [CW-1:0] C_RESYNC  = CW'(HALF_SMP + 1);
    localparam logic [CW-1:0] C_END_LO  = CW'(BIT_SMP - TOL);
    localparam logic [CW-1:0] C_LAST    = CW'(BIT_SMP - 1);
    localparam logic [CW-1:0] C_IDLE_M1 = CW'(IDLE_SMP - 1);
    localparam logic [IW-1:0] C_IDX_END = IW'(DATA_BITS);

    typedef struct packed {
        rx_state_e            st;
        logic [CW-1:0]        cnt;    // sample position / quiet count
        logic [CW-1:0]        hi;     // closing quiet count
        logic [IW-1:0]        idx;    // 0 = start bit, 1..DATA_BITS = data
        logic                 first;  // quarter-bit sample
        logic                 prev;   // previous strobe's level
        logic [DATA_BITS-1:0] sh;
        logic [DATA_BITS-1:0] data;
        logic                 valid;
        logic                 err;
        logic                 tim;
    } regs_t;

    regs_t r_q, r_d;
    logic  s_line, tick;
    logic  edge_seen, bad_code, bad_time;

    mrx_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(line_i), .q_o(s_line)
    );

    mrx_tick #(.DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.err   = 1'b0;
        edge_seen = 1'b0;
        bad_code  = 1'b0;
        bad_time  = 1'b0;
        if (tick) begin
            r_d.prev  = s_line;
            edge_seen = (s_line != r_q.prev);
            unique case (r_q.st)
                S_WAIT: begin
                    if (!s_line)                 r_d.cnt = '0;
                    else if (r_q.cnt == C_IDLE_M1) r_d.st = S_ARMED;
                    else                         r_d.cnt = r_q.cnt + 1'b1;
                end
                S_ARMED: begin
                    if (!s_line) begin
                        r_d.st  = S_BIT;
                        r_d.cnt = C_ONE;
                        r_d.idx = '0;
                        r_d.sh  = '0;
                    end
                end
                S_BIT: begin
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (edge_seen) begin
                        if (r_q.cnt >= C_MID_LO && r_q.cnt <= C_MID_HI)
                            r_d.cnt = C_RESYNC;
                        else if (!(r_q.cnt <= C_TOL || r_q.cnt >= C_END_LO))
                            bad_time = 1'b1;
                    end
                    if (r_q.cnt == C_Q1) r_d.first = s_line;
                    if (r_q.cnt == C_Q3) begin
                        if (s_line == r_q.first)  bad_code = 1'b1;
                        else if (r_q.idx == '0) begin
                            if (!s_line) bad_code = 1'b1;
                        end else begin
                            r_d.sh = {r_q.sh[DATA_BITS-2:0], s_line};
                        end
                    end
                    if (r_q.cnt == C_LAST) begin
                        r_d.cnt = '0;
                        if (r_q.idx == C_IDX_END) begin
                            r_d.st = S_STOP;
                            r_d.hi = '0;
                        end else begin
                            r_d.idx = r_q.idx + 1'b1;
                        end
                    end
                end
                S_STOP: begin
                    if (r_q.cnt <= C_TOL) r_d.cnt = r_q.cnt + 1'b1;
                    if (!s_line) begin
                        if (r_q.cnt > C_TOL) bad_time = 1'b1;
                        else                 r_d.hi = '0;
                    end else if (r_q.hi == C_IDLE_M1) begin
                        r_d.valid = 1'b1;
                        r_d.data  = r_q.sh;
                        r_d.st    = S_ARMED;
                    end else begin
                        r_d.hi = r_q.hi + 1'b1;
                    end
                end
                default: r_d.st = S_WAIT;
            endcase
            if (bad_time || bad_code) begin
                r_d.st  = S_WAIT;
                r_d.cnt = '0;
                r_d.err = 1'b1;
                r_d.tim = bad_time;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_WAIT, cnt: '0, hi: '0, idx: '0, first: 1'b0,
                     prev: 1'b1, sh: '0, data: '0, valid: 1'b0,
                     err: 1'b0, tim: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    mrx_flags u_flags (
        .low_bits_i (r_q.data[4:0]),
        .arc_on_o   (arc_on_o),
        .fade_run_o (fade_run_o),
        .lamp_fail_o(lamp_fail_o)
    );

    assign bus_idle_o      = (r_q.st == S_ARMED);
    assign rx_byte_o       = r_q.data;
    assign rx_valid_o      = r_q.valid;
    assign rx_err_o        = r_q.err;
    assign rx_err_timing_o = r_q.tim;
endmodule

// File: rtl/mrx_checker.sv
module mrx_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_idle,
    input logic [W-1:0] rx_byte,
    input logic         rx_valid,
    input logic         rx_err
);
    a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r6_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |=> !rx_err);

    a_r8_valid_not_err: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_err));

    a_r1_idle_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> bus_idle);

    a_r2_err_drops_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> !bus_idle);

    a_r11_byte_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte) |-> rx_valid);
endmodule

bind mrx_top mrx_checker #(.W(DATA_BITS)) u_mrx_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_idle(bus_idle_o),
    .rx_byte (rx_byte_o),
    .rx_valid(rx_valid_o),
    .rx_err  (rx_err_o)
);

// File: tb/mrx_top_test.sv
module mrx_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_CLK   = 64;   // 16 samples x divide-by-4
    localparam int BIT_CLK    = 2 * HALF_CLK;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_i = 1'b1;
    logic       bus_idle_o, rx_valid_o, rx_err_o, rx_err_timing_o;
    logic       arc_on_o, fade_run_o, lamp_fail_o;
    logic [7:0] rx_byte_o;

    int vec = 0;
    int mis = 0;
    int vcnt = 0;
    int ecnt = 0;
    logic [7:0] last_byte = 8'h00;
    logic       last_tim = 1'b0;
    logic [7:0] good_byte = 8'h00;

    mrx_top uut (
        .clk(clk), .rst_n(rst_n), .line_i(line_i),
        .bus_idle_o(bus_idle_o), .rx_byte_o(rx_byte_o),
        .rx_valid_o(rx_valid_o), .rx_err_o(rx_err_o),
        .rx_err_timing_o(rx_err_timing_o), .arc_on_o(arc_on_o),
        .fade_run_o(fade_run_o), .lamp_fail_o(lamp_fail_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rx_valid_o) begin vcnt++; last_byte = rx_byte_o; end
        if (rx_err_o)   begin ecnt++; last_tim = rx_err_timing_o; end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vec++;
        if (!ok) begin
            mis++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
        $finish;
    endtask

    function automatic logic [2:0] exp_flags(input logic [7:0] b);
        return {|b[4:0], b[4], b[2]};   // lamp, fade, arc
    endfunction

    task automatic hold(input logic lvl, input int n);
        line_i = lvl;
        repeat (n) @(negedge clk);
    endtask

    // one Manchester bit; j shifts the mid-bit edge in clocks
    task automatic send_bit(input logic b, input int j);
        hold(!b, HALF_CLK + j);
        hold(b, HALF_CLK - j);
    endtask

    task automatic clear_mon();
        vcnt = 0; ecnt = 0;
    endtask

    task automatic send_frame(input logic [7:0] b, input int jmax);
        send_bit(1'b1, 0);
        for (int i = 7; i >= 0; i--) begin
            int j;
            j = (jmax == 0) ? 0 : int'($urandom_range(2*jmax, 0)) - jmax;
            send_bit(b[i], j);
        end
        hold(1'b1, 3 * BIT_CLK);
    endtask

    task automatic expect_byte(input logic [7:0] b, input string req);
        logic [2:0] f;
        f = exp_flags(b);
        chk(vcnt == 1, req, vcnt, 1);
        chk(ecnt == 0, req, ecnt, 0);
        chk(last_byte == b && rx_byte_o == b, req, rx_byte_o, b);
        chk(arc_on_o == f[0], "R9 arc", arc_on_o, f[0]);
        chk(fade_run_o == f[1], "R9 fade", fade_run_o, f[1]);
        chk(lamp_fail_o == f[2], "R10 lamp", lamp_fail_o, f[2]);
        chk(bus_idle_o == 1'b1, "R8 idle after frame", bus_idle_o, 1);
        good_byte = b;
    endtask

    task automatic expect_err(input logic tim, input string req);
        chk(vcnt == 0, req, vcnt, 0);
        chk(ecnt == 1, req, ecnt, 1);
        chk(last_tim == tim, req, last_tim, tim);
        chk(rx_byte_o == good_byte, "R11 byte held", rx_byte_o, good_byte);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mis++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        logic [7:0] dir [6];
        int seed_unused;
        seed_unused = $urandom(32'h5eed);
        dir = '{8'h80, 8'h01, 8'h14, 8'hA5, 8'h00, 8'hFF};

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(bus_idle_o == 0 && rx_valid_o == 0 && rx_err_o == 0, "R1 reset",
            {bus_idle_o, rx_valid_o, rx_err_o}, 0);
        chk(rx_byte_o == 0 && lamp_fail_o == 0, "R1 reset byte", rx_byte_o, 0);
        repeat (225) @(negedge clk);
        chk(bus_idle_o == 0, "R1 quiet too short", bus_idle_o, 0);
        repeat (50) @(negedge clk);
        chk(bus_idle_o == 1, "R1 quiet reached", bus_idle_o, 1);

        // R4 R5 R9 R10: directed bytes, MSB first
        foreach (dir[k]) begin
            clear_mon();
            send_frame(dir[k], 0);
            expect_byte(dir[k], "R4 R5 directed");
        end

        // R7: largest accepted mid-edge shift, both directions
        clear_mon();
        send_bit(1'b1, 0);
        send_bit(1'b0, 10); send_bit(1'b1, 0); send_bit(1'b1, -10); send_bit(1'b0, 0);
        send_bit(1'b1, 0);  send_bit(1'b0, 10); send_bit(1'b0, 0);  send_bit(1'b1, 0);
        hold(1'b1, 3 * BIT_CLK);
        expect_byte(8'h69, "R7 edge shift accepted");

        // R5 R7: random bytes with small jitter
        for (int n = 0; n < 30; n++) begin
            logic [7:0] b;
            b = 8'($urandom);
            clear_mon();
            send_frame(b, 4);
            expect_byte(b, "R5 R7 random");
        end

        // R6: bit with no mid-bit transition
        clear_mon();
        send_bit(1'b1, 0); send_bit(1'b1, 0); send_bit(1'b0, 0);
        hold(1'b0, BIT_CLK);
        for (int i = 0; i < 5; i++) send_bit(1'b1, 0);
        hold(1'b1, 3 * BIT_CLK);
        expect_err(1'b0, "R6 coding violation");

        // R7: mid edge displaced far early
        clear_mon();
        send_bit(1'b1, 0); send_bit(1'b0, 0); send_bit(1'b1, 0);
        send_bit(1'b1, -40);
        for (int i = 0; i < 5; i++) send_bit(1'b0, 0);
        hold(1'b1, 3 * BIT_CLK);
        expect_err(1'b1, "R7 edge outside window");

        // R8: ninth bit where the closing quiet should be
        clear_mon();
        send_bit(1'b1, 0);
        for (int i = 0; i < 9; i++) send_bit(i[0], 0);
        hold(1'b1, 3 * BIT_CLK);
        expect_err(1'b1, "R8 extra bit");

        // R3: start level too short, then R2: frame too soon after
        clear_mon();
        hold(1'b0, 16);
        hold(1'b1, 150);
        expect_err(1'b0, "R3 bad start");
        chk(bus_idle_o == 0, "R1 idle after error", bus_idle_o, 0);
        clear_mon();
        send_frame(8'h3C, 0);
        chk(vcnt == 0 && ecnt == 0, "R2 frame ignored", vcnt + ecnt, 0);
        chk(rx_byte_o == good_byte, "R2 R11 byte held", rx_byte_o, good_byte);

        // recovery after the ignored frame
        clear_mon();
        send_frame(8'hC3, 0);
        expect_byte(8'hC3, "R2 recovery");

        report();
    end
endmodule